// File: doc/BRIEF.md
# Byte-Stream DMA Channel Controller

This block is a single DMA channel that sits between a byte-wide device FIFO and a 32-bit memory port. It is meant for a storage bus adapter. Software programs a start byte count and a start address while the channel is idle. It then writes a command byte whose two low bits pick the operation. Bit 7 of that byte picks the direction, and a set bit moves data toward memory. While the transfer runs, a working count and a working address advance one byte at a time, and both can be read at any point.

Toward memory, incoming bytes are packed into the byte lane given by the low address bits. A word write with byte enables goes out when the top lane fills or when the count runs out. Toward the device, one word is read from memory and its bytes are handed out in address order. The programmed length is capped at 2^16 bytes, or at 2^24 bytes when the extended-count input is high. It is then shortened so that it never crosses a 2^24 address boundary. A flush command pushes a partly filled word out to memory. An abort command stops the memory port. An interrupt line is raised from the sticky status bits.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Registers are selected by `reg_addr`: 0 command (byte), 1 start count, 2 start address, 3 working count, 4 working address, 5 status. Command bits [1:0] encode 0 idle, 1 flush, 2 abort and 3 start. A start loads the working count and address from the start registers.
- R2: The loaded working count is the start count limited to 2^16 when `ext_count_en` is low and to 2^24 when it is high.
- R3: The loaded working count is further limited so that start address + count never exceeds the next multiple of 2^24.
- R4: With command bit 7 set, received bytes go into lane address[1:0] of a word. A write request with the filled lanes enabled is issued at the word-aligned address when lane 3 fills or the count reaches zero. The request is held with a stable address until granted, and no byte is accepted while a write is pending.
- R5: With command bit 7 clear, a word is read at the word-aligned address, and its bytes from lane address[1:0] upward are sent to the device until lane 3 or the end of the count. The channel never accepts and sends bytes at the same time.
- R6: Status bit 3 (done) sets once the working count is zero and all data has left the channel. On completion the working count reads 0 and the working address reads start + length.
- R7: An abort command drops `mem_req` in the cycle after the write and sets status bit 2.
- R8: A flush command (code 1) stops byte intake and writes out any partly filled word. Status bit 5 sets only after no residual byte remains. With an empty packer it sets at once.
- R9: `mem_err` sampled with a grant sets status bit 1 and ends the transfer.
- R10: `irq` is high whenever any of status bits 1, 2, 3 or 4 is set. Status bit 4 follows the `dev_irq` input. Bit 0 reads 0.
- R11: An idle command stops the channel and clears status bits 1, 2, 3 and 5.
- R12: Writes to the start count and start address registers are ignored while a transfer is active.
- R13: After reset, the status, command and working count read 0, and `irq` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_count_en | input | 1 | Raises the length cap from 2^16 to 2^24 |
| irq | output | 1 | Interrupt request |
| dev_irq | input | 1 | Interrupt from the attached device |
| dev_rx_valid | input | 1 | Device byte available (toward memory) |
| dev_rx_data | input | 8 | Device byte |
| dev_rx_ready | output | 1 | Channel accepts a device byte |
| dev_tx_valid | output | 1 | Byte for the device (toward device) |
| dev_tx_data | output | 8 | Byte for the device |
| dev_tx_ready | input | 1 | Device accepts the byte |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory grant, completes the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned request address |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with the grant |
| mem_err | input | 1 | Error on the granted request |

## Verification
The assertions check the memory handshake on every cycle: a pending request keeps its address until it is granted, and no byte is taken while a write is outstanding. They also check that the two device directions are never active together, that an abort drops the request one cycle later and raises the interrupt, and that an idle command leaves only the device interrupt able to hold `irq` high. The scenarios show what no single-cycle property can: length capping and boundary clipping across address and count pairs, lane packing and byte enables for unaligned starts, byte order toward the device, the flush completing only once its residual word is granted, the error path, and start registers that ignore writes while a transfer runs.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_SCNT = 3'd1;
  localparam logic [2:0] RA_SADR = 3'd2;
  localparam logic [2:0] RA_WCNT = 3'd3;
  localparam logic [2:0] RA_WADR = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;

  localparam int ST_ERR  = 1;
  localparam int ST_ABT  = 2;
  localparam int ST_DONE = 3;
  localparam int ST_DEVI = 4;
  localparam int ST_FLSH = 5;

  localparam int CMD_DIR_BIT = 7;

  typedef struct packed {
    logic start;
    logic flush;
    logic abort;
    logic idle;
    logic to_mem;
  } dma_ctl_t;

endpackage

// File: rtl/dma_len_clip.sv
module dma_len_clip #(
  parameter int ADDR_W     = 32,
  parameter int CAP_LO_LOG = 16,
  parameter int CAP_HI_LOG = 24,
  parameter int BOUND_LOG  = 24,
  parameter int CNT_W      = 25
) (
  input  logic                 ext_en,
  input  logic [ADDR_W-1:0]    req_len,
  input  logic [BOUND_LOG-1:0] base_addr,
  output logic [CNT_W-1:0]     eff_len
);
  localparam int WIDE = ADDR_W + 1;

  logic [WIDE-1:0] cap, req_w, lim, room, eff_w;

  always_comb begin
    cap   = ext_en ? (WIDE'(1) << CAP_HI_LOG) : (WIDE'(1) << CAP_LO_LOG);
    req_w = {1'b0, req_len};
    lim   = (req_w > cap) ? cap : req_w;
    room  = (WIDE'(1) << BOUND_LOG) - WIDE'(base_addr);
    eff_w = (lim > room) ? room : lim;
  end

  assign eff_len = eff_w[CNT_W-1:0];

endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             busy,
  input  logic [CNT_W-1:0] work_cnt,
  input  logic [REG_W-1:0] work_adr,
  input  logic             ev_done,
  input  logic             ev_err,
  input  logic             ev_flush_ok,
  input  logic             dev_irq,
  output dma_ctl_t         ctl,
  output logic [REG_W-1:0] start_cnt,
  output logic [REG_W-1:0] start_adr,
  output logic             irq
);
  logic [7:0]       cmd_q, cmd_d;
  logic [REG_W-1:0] scnt_q, scnt_d, sadr_q, sadr_d;
  logic             err_q, err_d, abt_q, abt_d, done_q, done_d, flo_q, flo_d;
  logic             cmd_wr, scnt_wr, sadr_wr, stat_en;
  dma_op_e          op;
  logic [REG_W-1:0] status;

  assign cmd_wr  = reg_wr && (reg_addr == RA_CMD);
  assign scnt_wr = reg_wr && (reg_addr == RA_SCNT) && !busy;
  assign sadr_wr = reg_wr && (reg_addr == RA_SADR) && !busy;
  assign op      = dma_op_e'(reg_wdata[1:0]);

  always_comb begin
    ctl.start  = cmd_wr && (op == OP_START);
    ctl.flush  = cmd_wr && (op == OP_FLUSH);
    ctl.abort  = cmd_wr && (op == OP_ABORT);
    ctl.idle   = cmd_wr && (op == OP_IDLE);
    ctl.to_mem = reg_wdata[CMD_DIR_BIT];
  end

  always_comb begin
    cmd_d  = cmd_wr ? reg_wdata[7:0] : cmd_q;
    scnt_d = scnt_wr ? reg_wdata : scnt_q;
    sadr_d = sadr_wr ? reg_wdata : sadr_q;
    err_d  = err_q  | ev_err;
    abt_d  = abt_q;
    done_d = done_q | ev_done;
    flo_d  = flo_q  | ev_flush_ok;
    if (cmd_wr) begin
      unique case (op)
        OP_IDLE: begin
          err_d = 1'b0; abt_d = 1'b0; done_d = 1'b0; flo_d = 1'b0;
        end
        OP_ABORT: abt_d = 1'b1;
        OP_START: begin
          done_d = 1'b0; flo_d = 1'b0;
        end
        OP_FLUSH: flo_d = 1'b0;
      endcase
    end
  end

  assign stat_en = cmd_wr | ev_done | ev_err | ev_flush_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      scnt_q <= '0;
      sadr_q <= '0;
      err_q  <= 1'b0;
      abt_q  <= 1'b0;
      done_q <= 1'b0;
      flo_q  <= 1'b0;
    end else begin
      if (cmd_wr)  cmd_q  <= cmd_d;
      if (scnt_wr) scnt_q <= scnt_d;
      if (sadr_wr) sadr_q <= sadr_d;
      if (stat_en) begin
        err_q  <= err_d;
        abt_q  <= abt_d;
        done_q <= done_d;
        flo_q  <= flo_d;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_ERR]  = err_q;
    status[ST_ABT]  = abt_q;
    status[ST_DONE] = done_q;
    status[ST_DEVI] = dev_irq;
    status[ST_FLSH] = flo_q;
  end

  always_comb begin
    unique case (reg_addr)
      RA_CMD:  reg_rdata = REG_W'(cmd_q);
      RA_SCNT: reg_rdata = scnt_q;
      RA_SADR: reg_rdata = sadr_q;
      RA_WCNT: reg_rdata = REG_W'(work_cnt);
      RA_WADR: reg_rdata = work_adr;
      RA_STAT: reg_rdata = status;
      default: reg_rdata = '0;
    endcase
  end

  assign start_cnt = scnt_q;
  assign start_adr = sadr_q;
  assign irq       = err_q | abt_q | done_q | dev_irq;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dma_ctl_t            ctl,
  input  logic [CNT_W-1:0]    start_len,
  input  logic [ADDR_W-1:0]   start_adr,
  output logic                busy,
  output logic [CNT_W-1:0]    work_cnt,
  output logic [ADDR_W-1:0]   work_adr,
  output logic                ev_done,
  output logic                ev_err,
  output logic                ev_flush_ok,
  input  logic                dev_rx_valid,
  input  logic [7:0]          dev_rx_data,
  output logic                dev_rx_ready,
  output logic                dev_tx_valid,
  output logic [7:0]          dev_tx_data,
  input  logic                dev_tx_ready,
  output logic                mem_req,
  input  logic                mem_gnt,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_err
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES);

  logic              act_q, act_d, dir_q, dir_d, req_q, req_d, fl_q, fl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] adr_q, adr_d, radr_q, radr_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic [LANES-1:0]  be_q, be_d;
  logic [LW-1:0]     lane;
  logic              last_lane, last_byte, cnt_zero, rx_fire, tx_fire, gnt_fire;
  logic [ADDR_W-1:0] word_adr;

  assign lane      = adr_q[LW-1:0];
  assign last_lane = &lane;
  assign cnt_zero  = (cnt_q == '0);
  assign last_byte = (cnt_q == CNT_W'(1));
  assign word_adr  = {adr_q[ADDR_W-1:LW], {LW{1'b0}}};

  assign dev_rx_ready = act_q && dir_q && !req_q && !cnt_zero;
  assign dev_tx_valid = act_q && !dir_q && (be_q != '0) && !cnt_zero;
  assign dev_tx_data  = buf_q[int'(lane)*8 +: 8];
  assign rx_fire      = dev_rx_ready && dev_rx_valid;
  assign tx_fire      = dev_tx_valid && dev_tx_ready;
  assign gnt_fire     = req_q && mem_gnt;

  always_comb begin
    act_d = act_q; dir_d = dir_q; req_d = req_q; fl_d = fl_q;
    cnt_d = cnt_q; adr_d = adr_q; radr_d = radr_q;
    buf_d = buf_q; be_d = be_q;
    ev_done = 1'b0; ev_err = 1'b0; ev_flush_ok = 1'b0;
    if (ctl.abort || ctl.idle) begin
      act_d = 1'b0; req_d = 1'b0; fl_d = 1'b0; be_d = '0;
    end else if (ctl.start) begin
      act_d = 1'b1; dir_d = ctl.to_mem; req_d = 1'b0; fl_d = 1'b0;
      cnt_d = start_len; adr_d = start_adr; buf_d = '0; be_d = '0;
    end else if (ctl.flush) begin
      act_d = 1'b0; fl_d = 1'b1;
      if (!dir_q) begin
        req_d = 1'b0; be_d = '0;
      end
    end else begin
      if (gnt_fire) begin
        req_d = 1'b0;
        if (mem_err) begin
          ev_err = 1'b1; act_d = 1'b0; be_d = '0;
        end else if (dir_q) begin
          be_d = '0;
        end else begin
          buf_d = mem_rdata; be_d = '1;
        end
      end
      if (rx_fire) begin
        buf_d[int'(lane)*8 +: 8] = dev_rx_data;
        be_d[lane] = 1'b1;
        adr_d = adr_q + ADDR_W'(1);
        cnt_d = cnt_q - CNT_W'(1);
        if (last_lane || last_byte) begin
          req_d = 1'b1; radr_d = word_adr;
        end
      end
      if (tx_fire) begin
        adr_d = adr_q + ADDR_W'(1);
        cnt_d = cnt_q - CNT_W'(1);
        if (last_lane || last_byte) be_d = '0;
      end
      if (act_q && !dir_q && !req_q && (be_q == '0) && !cnt_zero) begin
        req_d = 1'b1; radr_d = word_adr;
      end
      if (act_q && cnt_zero && !req_q && (be_q == '0)) begin
        act_d = 1'b0; ev_done = 1'b1;
      end
      if (fl_q) begin
        if (dir_q && (be_q != '0) && !req_q) begin
          req_d = 1'b1; radr_d = word_adr;
        end
        if (!req_q && (!dir_q || (be_q == '0))) begin
          fl_d = 1'b0; ev_flush_ok = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; dir_q <= 1'b0; req_q <= 1'b0; fl_q <= 1'b0;
      cnt_q <= '0; adr_q <= '0; radr_q <= '0; buf_q <= '0; be_q <= '0;
    end else begin
      act_q  <= act_d;
      dir_q  <= dir_d;
      req_q  <= req_d;
      fl_q   <= fl_d;
      cnt_q  <= cnt_d;
      adr_q  <= adr_d;
      radr_q <= radr_d;
      buf_q  <= buf_d;
      be_q   <= be_d;
    end
  end

  assign busy      = act_q;
  assign work_cnt  = cnt_q;
  assign work_adr  = adr_q;
  assign mem_req   = req_q;
  assign mem_we    = dir_q;
  assign mem_addr  = radr_q;
  assign mem_be    = dir_q ? be_q : '1;
  assign mem_wdata = buf_q;

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CAP_LO_LOG = 16,
  parameter int CAP_HI_LOG = 24,
  parameter int BOUND_LOG  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [ADDR_W-1:0]   reg_wdata,
  output logic [ADDR_W-1:0]   reg_rdata,
  input  logic                ext_count_en,
  output logic                irq,
  input  logic                dev_irq,
  input  logic                dev_rx_valid,
  input  logic [7:0]          dev_rx_data,
  output logic                dev_rx_ready,
  output logic                dev_tx_valid,
  output logic [7:0]          dev_tx_data,
  input  logic                dev_tx_ready,
  output logic                mem_req,
  input  logic                mem_gnt,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_err
);
  localparam int CNT_W = ((CAP_HI_LOG > BOUND_LOG) ? CAP_HI_LOG : BOUND_LOG) + 1;

  logic [1:0]        rst_sync;
  logic              rst_core_n;
  dma_ctl_t          ctl;
  logic              busy, ev_done, ev_err, ev_flush_ok;
  logic [CNT_W-1:0]  work_cnt, eff_len;
  logic [ADDR_W-1:0] work_adr, start_cnt, start_adr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  dma_regs #(.REG_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .work_cnt(work_cnt), .work_adr(work_adr),
    .ev_done(ev_done), .ev_err(ev_err), .ev_flush_ok(ev_flush_ok),
    .dev_irq(dev_irq), .ctl(ctl), .start_cnt(start_cnt), .start_adr(start_adr),
    .irq(irq)
  );

  dma_len_clip #(
    .ADDR_W(ADDR_W), .CAP_LO_LOG(CAP_LO_LOG), .CAP_HI_LOG(CAP_HI_LOG),
    .BOUND_LOG(BOUND_LOG), .CNT_W(CNT_W)
  ) u_clip (
    .ext_en(ext_count_en), .req_len(start_cnt),
    .base_addr(start_adr[BOUND_LOG-1:0]), .eff_len(eff_len)
  );

  dma_xfer_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_core_n), .ctl(ctl),
    .start_len(eff_len), .start_adr(start_adr),
    .busy(busy), .work_cnt(work_cnt), .work_adr(work_adr),
    .ev_done(ev_done), .ev_err(ev_err), .ev_flush_ok(ev_flush_ok),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

endmodule

// File: rtl/dma_chan_sva.sv
module dma_chan_sva
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [1:0]        cmd_op,
  input logic              irq,
  input logic              dev_irq,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dev_rx_ready,
  input logic              dev_tx_valid
);
  logic cmd_wr;
  assign cmd_wr = reg_wr && (reg_addr == RA_CMD);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !cmd_wr) |=> (mem_req && $stable(mem_addr))); // R4

  AST_NO_RX_WHILE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !dev_rx_ready); // R4

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rx_ready && dev_tx_valid)); // R5

  AST_ABORT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_op == 2'd2) |=> !mem_req); // R7

  AST_ABORT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_op == 2'd2) |=> irq); // R10

  AST_IDLE_QUIETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_op == 2'd0) |=> (!irq || dev_irq)); // R11

endmodule

bind dma_chan_ctrl dma_chan_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd_op(reg_wdata[1:0]), .irq(irq), .dev_irq(dev_irq),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
  .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid)
);

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, ext_count_en, irq, dev_irq;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        dev_rx_valid, dev_rx_ready, dev_tx_valid, dev_tx_ready;
  logic [7:0]  dev_rx_data, dev_tx_data;
  logic        mem_req, mem_gnt, mem_we, mem_err;
  logic [3:0]  mem_be;

  int errors = 0, checks = 0;
  logic [7:0]  src [0:15];
  int src_n = 0, src_idx = 0;
  logic [31:0] wr_adr [0:15], wr_dat [0:15];
  logic [3:0]  wr_be [0:15];
  int wr_n = 0, rd_n = 0, tx_n = 0;
  logic [7:0]  tx_log [0:31];
  logic gnt_en = 1'b0, err_en = 1'b0, finished = 1'b0;

  dma_chan_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_count_en(ext_count_en),
    .irq(irq), .dev_irq(dev_irq), .dev_rx_valid(dev_rx_valid),
    .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // device and memory models, evaluated away from the rising edge
  always @(negedge clk) begin
    dev_rx_valid = (src_idx < src_n);
    dev_rx_data  = (src_idx < src_n) ? src[src_idx] : 8'h00;
    if (rst_n && dev_rx_valid && dev_rx_ready) src_idx++;
    mem_gnt = gnt_en && mem_req;
    mem_err = err_en;
    for (int k = 0; k < 4; k++) mem_rdata[k*8 +: 8] = (mem_addr[7:0] + 8'(k)) ^ 8'h5A;
    if (mem_gnt) begin
      if (mem_we) begin
        wr_adr[wr_n] = mem_addr; wr_dat[wr_n] = mem_wdata; wr_be[wr_n] = mem_be; wr_n++;
      end else rd_n++;
    end
    if (dev_tx_valid && dev_tx_ready) begin
      tx_log[tx_n] = dev_tx_data; tx_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    reg_addr = a; #1;
    v = reg_rdata;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim && !irq; i++) @(negedge clk);
    #1;
  endtask

  // {ext_count_en, start count, start address, expected working count}
  localparam logic [96:0] CLIP_VEC [0:7] = '{
    {1'b0, 32'h0000_0100, 32'h0000_1000, 32'h0000_0100},
    {1'b0, 32'h0002_0000, 32'h0000_0000, 32'h0001_0000},
    {1'b1, 32'h0002_0000, 32'h0000_0000, 32'h0002_0000},
    {1'b1, 32'h0200_0000, 32'h0000_0000, 32'h0100_0000},
    {1'b0, 32'h0000_0100, 32'h00FF_FF80, 32'h0000_0080},
    {1'b1, 32'h0080_0000, 32'h12FF_0000, 32'h0001_0000},
    {1'b0, 32'h0001_0000, 32'h0000_0000, 32'h0001_0000},
    {1'b1, 32'h0000_0010, 32'h00FF_FFF0, 32'h0000_0010}
  };

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    ext_count_en = 1'b0; dev_irq = 1'b0; dev_tx_ready = 1'b1;
    dev_rx_valid = 1'b0; dev_rx_data = '0; mem_gnt = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(4);

    // R13 reset state
    rd(3'd5, v); chk("R13 status", v, 32'h0);
    rd(3'd0, v); chk("R13 command", v, 32'h0);
    rd(3'd3, v); chk("R13 work count", v, 32'h0);
    chk("R13 irq", {31'b0, irq}, 32'h0);
    chk("R13 mem_req", {31'b0, mem_req}, 32'h0);

    // R2 R3 clipping table, device direction with memory stalled
    gnt_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ext_count_en = CLIP_VEC[i][96];
      wr(3'd1, CLIP_VEC[i][95:64]);
      wr(3'd2, CLIP_VEC[i][63:32]);
      wr(3'd0, 32'h03);
      rd(3'd3, v); chk($sformatf("R2/R3 clip vector %0d", i), v, CLIP_VEC[i][31:0]);
      rd(3'd4, v); chk("R1 work address loaded", v, CLIP_VEC[i][63:32]);
      wr(3'd0, 32'h00);
    end
    ext_count_en = 1'b0;

    // R12 start registers ignored while active
    wr(3'd1, 32'h40); wr(3'd2, 32'h700); wr(3'd0, 32'h03);
    wr(3'd1, 32'h99); wr(3'd2, 32'h1234);
    rd(3'd1, v); chk("R12 count held", v, 32'h40);
    rd(3'd2, v); chk("R12 address held", v, 32'h700);
    wr(3'd0, 32'h00);
    wr(3'd1, 32'h99);
    rd(3'd1, v); chk("R12 count writable when idle", v, 32'h99);

    // R4 R6 toward memory, unaligned start
    gnt_en = 1'b1; wr_n = 0;
    src[0]=8'h11; src[1]=8'h22; src[2]=8'h33; src[3]=8'h44; src[4]=8'h55; src[5]=8'h66;
    src_idx = 0; src_n = 6;
    wr(3'd1, 32'd6); wr(3'd2, 32'h101); wr(3'd0, 32'h83);
    wait_irq(100);
    chk("R4 write count", wr_n, 2);
    chk("R4 first addr", wr_adr[0], 32'h100);
    chk("R4 first be", {28'b0, wr_be[0]}, 32'hE);
    chk("R4 first data", wr_dat[0] & 32'hFFFFFF00, 32'h33221100);
    chk("R4 second addr", wr_adr[1], 32'h104);
    chk("R4 second be", {28'b0, wr_be[1]}, 32'h7);
    chk("R4 second data", wr_dat[1] & 32'h00FFFFFF, 32'h00665544);
    rd(3'd5, v); chk("R6 done status", v, 32'h08);
    chk("R10 irq on done", {31'b0, irq}, 32'h1);
    rd(3'd3, v); chk("R6 work count zero", v, 32'h0);
    rd(3'd4, v); chk("R6 work address end", v, 32'h107);
    wr(3'd0, 32'h00);
    rd(3'd5, v); chk("R11 idle clears done", v, 32'h0);
    src_n = 0; src_idx = 0;

    // R5 toward device
    tx_n = 0; rd_n = 0;
    wr(3'd1, 32'd5); wr(3'd2, 32'h202); wr(3'd0, 32'h03);
    wait_irq(100);
    chk("R5 byte count", tx_n, 5);
    chk("R5 read count", rd_n, 2);
    for (int i = 0; i < 5; i++)
      chk("R5 byte order", {24'b0, tx_log[i]}, {24'b0, (8'h02 + 8'(i)) ^ 8'h5A});
    rd(3'd5, v); chk("R6 done after read", v, 32'h08);
    wr(3'd0, 32'h00);

    // R7 abort with a stalled write pending
    gnt_en = 1'b0; wr_n = 0;
    src[0]=8'hA0; src[1]=8'hA1; src[2]=8'hA2; src[3]=8'hA3; src_idx = 0; src_n = 4;
    wr(3'd1, 32'd8); wr(3'd2, 32'h600); wr(3'd0, 32'h83);
    idle_cycles(8);
    chk("R4 request pending", {31'b0, mem_req}, 32'h1);
    wr(3'd0, 32'h02);
    chk("R7 mem_req dropped", {31'b0, mem_req}, 32'h0);
    rd(3'd5, v); chk("R7 abort status", v, 32'h04);
    chk("R10 irq on abort", {31'b0, irq}, 32'h1);
    gnt_en = 1'b1; idle_cycles(4);
    chk("R7 no write after abort", wr_n, 0);
    wr(3'd0, 32'h00);
    rd(3'd5, v); chk("R11 idle clears abort", v, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R8 flush with a residual partial word
    gnt_en = 1'b0; wr_n = 0;
    src[0]=8'hAA; src[1]=8'hBB; src_idx = 0; src_n = 2;
    wr(3'd1, 32'd8); wr(3'd2, 32'h400); wr(3'd0, 32'h83);
    idle_cycles(6);
    wr(3'd0, 32'h81);
    idle_cycles(3);
    rd(3'd5, v); chk("R8 no completion with residual", v, 32'h0);
    gnt_en = 1'b1; idle_cycles(4);
    rd(3'd5, v); chk("R8 completion after flush", v, 32'h20);
    chk("R8 flush write count", wr_n, 1);
    chk("R8 flush addr", wr_adr[0], 32'h400);
    chk("R8 flush be", {28'b0, wr_be[0]}, 32'h3);
    chk("R8 flush data", wr_dat[0] & 32'h0000FFFF, 32'h0000BBAA);
    wr(3'd0, 32'h00);
    rd(3'd5, v); chk("R11 idle clears flush bit", v, 32'h0);
    src_n = 0; src_idx = 0;

    // R8 flush with nothing buffered
    wr(3'd1, 32'd8); wr(3'd2, 32'h500); wr(3'd0, 32'h83);
    wr(3'd0, 32'h81);
    idle_cycles(2);
    rd(3'd5, v); chk("R8 empty flush completes", v, 32'h20);
    wr(3'd0, 32'h00);

    // R9 memory error
    err_en = 1'b1; tx_n = 0;
    wr(3'd1, 32'd4); wr(3'd2, 32'h300); wr(3'd0, 32'h03);
    wait_irq(50);
    rd(3'd5, v); chk("R9 error status", v, 32'h02);
    chk("R9 no bytes sent", tx_n, 0);
    chk("R9 request ended", {31'b0, mem_req}, 32'h0);
    err_en = 1'b0;
    wr(3'd0, 32'h00);

    // R6 zero-length transfer
    wr(3'd1, 32'd0); wr(3'd2, 32'h800); wr(3'd0, 32'h03);
    idle_cycles(3);
    rd(3'd5, v); chk("R6 zero length done", v, 32'h08);
    wr(3'd0, 32'h00);

    // R10 device interrupt
    @(negedge clk); #1 dev_irq = 1'b1;
    rd(3'd5, v); chk("R10 device status bit", v, 32'h10);
    chk("R10 irq from device", {31'b0, irq}, 32'h1);
    #1 dev_irq = 1'b0; #1;
    chk("R10 irq follows device", {31'b0, irq}, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule